// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block decides, at the moment the core offers an entry opportunity, whether execution must leave its normal flow, and produces every piece of state that changes when it does. Level-sensitive interrupt lines are captured each cycle into a pending-status vector and qualified by a per-line enable mask, the global interrupt enable and the debug-state flag. A synchronous exception request carries a primary cause code and a sub-code. When the core pulses the take strobe, the block picks the winning source and commits the new privilege and enable state, the saved previous state, the return address, cause, bad-address and faulting-instruction values, and the redirected PC, all on the same clock edge.

Three entry paths exist. A normal entry saves into the ordinary saved-mode and return registers. A refill entry, selected by the refill flag input, saves into a separate set, forces direct-address mode and stores the PC divided by four. A debug entry, taken on a breakpoint or on an interrupt that arrives while already in debug state, writes only the debug registers. Handler addresses are computed from a base and a programmable vector spacing of four times a power of two; a spacing setting of zero places every vector on the base.

The live mode fields (privilege, enable, address-mode bits), the base addresses, the spacing setting, the enable mask and the refill flag come from the surrounding control-register file as inputs; the block returns the values to be written back as registered outputs.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Each cycle the pending-status output takes the value of the interrupt lines from the previous clock edge, one bit per line; the pending indicator is the OR of all pending bits and ignores the enable mask.
- R2: The interrupt-available output is 1 exactly when the live global enable is 1, the debug-state output is 0, and the AND of pending status and enable mask is nonzero.
- R3: An interrupt entry chooses the highest-numbered pending and enabled line and branches to base + (64 + line) × spacing; the cause code and sub-code outputs become 0.
- R4: The spacing is 0 when the 3-bit spacing setting is 0 and 4 << setting otherwise.
- R5: A non-refill exception entry branches to base + primary code × spacing and writes the primary code and sub-code to the cause outputs.
- R6: An exception request wins over a simultaneously available interrupt; a take strobe with neither an exception request nor an eligible interrupt changes no output and raises no redirect.
- R7: An exception with code 0x1A (breakpoint) sets the debug-state, breakpoint-flag outputs, writes 0xC into the debug code output, copies the PC into the debug return output and branches to base + 0x480, leaving the mode, saved-mode, cause and return outputs untouched.
- R8: When debug state is 1, the global enable is 1 and a pending line is enabled, a take with no exception sets the debug-interrupt flag, copies the PC into the debug return output and branches to base + 0x480.
- R9: With the refill flag set, a non-debug entry saves live privilege and enable into the refill saved-mode outputs, stores PC[63:2] in the refill return output, forces direct-address mode to 1 and paging to 0; an exception then branches to the refill base, an interrupt still to its vector.
- R10: With the refill flag clear, a non-debug entry saves live privilege and enable into the saved-mode outputs, stores the PC in the return output, and copies the live address-mode bits into the mode outputs.
- R11: Every non-debug entry sets the privilege output to 0 and the enable output to 0.
- R12: Exceptions with codes 0x0B to 0x12 load the PC into the bad-address output; other codes and interrupts leave it unchanged.
- R13: Every exception request captures the instruction word into the faulting-instruction output except code 0x00, code 0x03 and code 0x08 with sub-code 0; interrupts never capture it.
- R14: The redirect output is a one-cycle pulse in the cycle after a take that caused an entry, when the PC output holds the new target; after reset all outputs are 0 except direct-address mode, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NIRQ | Level interrupt request lines |
| lie_i | input | NIRQ | Per-line interrupt enable mask |
| vs_i | input | VSW | Vector spacing setting |
| base_i | input | XLEN | Handler base address |
| rf_base_i | input | XLEN | Refill handler address |
| rf_flag_i | input | 1 | Refill entry in progress |
| cur_plv_i | input | 2 | Live privilege level |
| cur_ie_i | input | 1 | Live global interrupt enable |
| cur_da_i | input | 1 | Live direct-address mode bit |
| cur_pg_i | input | 1 | Live paging bit |
| pc_i | input | XLEN | PC of the instruction at the entry point |
| insn_i | input | 32 | Instruction word at that PC |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 6 | Primary cause code |
| exc_sub_i | input | 9 | Cause sub-code |
| take_i | input | 1 | Entry opportunity strobe |
| irq_pending_o | output | 1 | Any pending bit set |
| int_avail_o | output | 1 | Interrupt eligible for normal entry |
| redirect_o | output | 1 | Entry committed last cycle |
| pc_o | output | XLEN | New PC |
| pending_o | output | NIRQ | Pending-status field |
| cause_code_o | output | 6 | Recorded primary cause |
| cause_sub_o | output | 9 | Recorded sub-code |
| mode_plv_o | output | 2 | New privilege level |
| mode_ie_o | output | 1 | New global enable |
| mode_da_o | output | 1 | New direct-address bit |
| mode_pg_o | output | 1 | New paging bit |
| sav_plv_o | output | 2 | Saved privilege, normal path |
| sav_ie_o | output | 1 | Saved enable, normal path |
| rf_sav_plv_o | output | 2 | Saved privilege, refill path |
| rf_sav_ie_o | output | 1 | Saved enable, refill path |
| ret_pc_o | output | XLEN | Return address, normal path |
| rf_ret_o | output | XLEN-2 | Return address / 4, refill path |
| badv_o | output | XLEN | Bad-address value |
| badi_o | output | 32 | Faulting instruction word |
| dbg_state_o | output | 1 | Debug state |
| dbg_bp_o | output | 1 | Debug entry by breakpoint |
| dbg_int_o | output | 1 | Debug entry by interrupt |
| dbg_code_o | output | 6 | Debug exception code |
| dbg_ret_o | output | XLEN | Debug return address |

## Verification
A wrong pending capture or a mis-gated enable shows one cycle after the line change on the pending and interrupt-available outputs, before any take is offered. A wrong kind choice, priority pick or spacing shows on the cycle after the take as a wrong PC, a missing redirect pulse, or a save landing in the wrong register set. A stale debug-state flag shows at the next interrupt take, which goes to base + 0x480 instead of its vector; the bench compares every output after every take against a model, so such errors surface on the first affected entry.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CODE_W = 6;
  localparam int SUB_W  = 9;

  localparam logic [CODE_W-1:0] C_INT  = 6'h00;
  localparam logic [CODE_W-1:0] C_PIF  = 6'h03;
  localparam logic [CODE_W-1:0] C_ADE  = 6'h08;
  localparam logic [CODE_W-1:0] C_SYS  = 6'h0B;
  localparam logic [CODE_W-1:0] C_BRK  = 6'h0C;
  localparam logic [CODE_W-1:0] C_INE  = 6'h0D;
  localparam logic [CODE_W-1:0] C_IPE  = 6'h0E;
  localparam logic [CODE_W-1:0] C_FPD  = 6'h0F;
  localparam logic [CODE_W-1:0] C_VD1  = 6'h10;
  localparam logic [CODE_W-1:0] C_VD2  = 6'h11;
  localparam logic [CODE_W-1:0] C_FPE  = 6'h12;
  localparam logic [CODE_W-1:0] C_DBP  = 6'h1A;
  localparam logic [CODE_W-1:0] DBG_ECODE = 6'h0C;

  typedef enum logic [2:0] {
    K_NONE, K_EXC, K_INT, K_DBG_BP, K_DBG_INT
  } entry_kind_e;
endpackage

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
  parameter int N  = 13,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] win_oh;

  for (genvar i = 0; i < N; i++) begin : g_oh
    if (i == N-1) begin : g_top
      assign win_oh[i] = req_i[i];
    end else begin : g_low
      assign win_oh[i] = req_i[i] & ~(|req_i[N-1:i+1]);
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (win_oh[i]) idx_o = idx_o | IW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/exc_vec_calc.sv
module exc_vec_calc #(
  parameter int AW  = 64,
  parameter int IW  = 7,
  parameter int VSW = 3
) (
  input  logic [AW-1:0]  base_i,
  input  logic [IW-1:0]  idx_i,
  input  logic [VSW-1:0] vs_i,
  output logic [AW-1:0]  tgt_o
);
  logic [AW-1:0] ofs;

  always_comb begin
    if (vs_i == '0) ofs = '0;
    else            ofs = AW'(idx_i) << (32'(vs_i) + 32'd2);
  end

  assign tgt_o = base_i + ofs;
endmodule

// File: rtl/exc_cause_class.sv
module exc_cause_class
  import exc_entry_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic [SUB_W-1:0]  sub_i,
  output logic              is_dbp_o,
  output logic              set_badv_o,
  output logic              keep_badi_o
);
  always_comb begin
    is_dbp_o = (code_i == C_DBP);
    case (code_i)
      C_SYS, C_BRK, C_INE, C_IPE, C_FPD, C_VD1, C_VD2, C_FPE: set_badv_o = 1'b1;
      default:                                                 set_badv_o = 1'b0;
    endcase
    keep_badi_o = !((code_i == C_INT) || (code_i == C_PIF) ||
                    ((code_i == C_ADE) && (sub_i == '0)));
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NIRQ     = 13,
  parameter int EXT_BASE = 64,
  parameter int VSW      = 3,
  parameter int DBG_OFS  = 1152
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NIRQ-1:0]     irq_i,
  input  logic [NIRQ-1:0]     lie_i,
  input  logic [VSW-1:0]      vs_i,
  input  logic [XLEN-1:0]     base_i,
  input  logic [XLEN-1:0]     rf_base_i,
  input  logic                rf_flag_i,
  input  logic [1:0]          cur_plv_i,
  input  logic                cur_ie_i,
  input  logic                cur_da_i,
  input  logic                cur_pg_i,
  input  logic [XLEN-1:0]     pc_i,
  input  logic [31:0]         insn_i,
  input  logic                exc_valid_i,
  input  logic [CODE_W-1:0]   exc_code_i,
  input  logic [SUB_W-1:0]    exc_sub_i,
  input  logic                take_i,
  output logic                irq_pending_o,
  output logic                int_avail_o,
  output logic                redirect_o,
  output logic [XLEN-1:0]     pc_o,
  output logic [NIRQ-1:0]     pending_o,
  output logic [CODE_W-1:0]   cause_code_o,
  output logic [SUB_W-1:0]    cause_sub_o,
  output logic [1:0]          mode_plv_o,
  output logic                mode_ie_o,
  output logic                mode_da_o,
  output logic                mode_pg_o,
  output logic [1:0]          sav_plv_o,
  output logic                sav_ie_o,
  output logic [1:0]          rf_sav_plv_o,
  output logic                rf_sav_ie_o,
  output logic [XLEN-1:0]     ret_pc_o,
  output logic [XLEN-3:0]     rf_ret_o,
  output logic [XLEN-1:0]     badv_o,
  output logic [31:0]         badi_o,
  output logic                dbg_state_o,
  output logic                dbg_bp_o,
  output logic                dbg_int_o,
  output logic [CODE_W-1:0]   dbg_code_o,
  output logic [XLEN-1:0]     dbg_ret_o
);
  localparam int IRQ_IW  = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam int VIDX_W0 = $clog2(EXT_BASE + NIRQ);
  localparam int VIDX_W  = (VIDX_W0 > CODE_W) ? VIDX_W0 : CODE_W;

  // ---------------- state ----------------
  logic [NIRQ-1:0]   pend_q;
  logic              redir_q;
  logic [XLEN-1:0]   pc_q, ret_q, badv_q, dret_q;
  logic [XLEN-3:0]   rfret_q;
  logic [31:0]       badi_q;
  logic [CODE_W-1:0] code_q, dcode_q;
  logic [SUB_W-1:0]  sub_q;
  logic [1:0]        plv_q, splv_q, rfplv_q;
  logic              ie_q, da_q, pg_q, sie_q, rfie_q;
  logic              dst_q, dbp_q, dint_q;

  // ---------------- decode ----------------
  logic [NIRQ-1:0]   live;
  logic              live_any;
  logic [IRQ_IW-1:0] win_line;
  logic              is_dbp, set_badv, keep_badi;
  logic              int_norm, int_dbg;
  entry_kind_e       kind;
  logic              commit, enter_norm, enter_dbg, badv_en, badi_en;
  logic [VIDX_W-1:0] vidx;
  logic [XLEN-1:0]   vec_pc, tgt_pc;
  logic              da_d, pg_d;
  logic [CODE_W-1:0] code_d;
  logic [SUB_W-1:0]  sub_d;

  assign live = pend_q & lie_i;

  exc_prio_enc #(.N(NIRQ), .IW(IRQ_IW)) u_prio (
    .req_i (live),
    .any_o (live_any),
    .idx_o (win_line)
  );

  exc_cause_class u_class (
    .code_i      (exc_code_i),
    .sub_i       (exc_sub_i),
    .is_dbp_o    (is_dbp),
    .set_badv_o  (set_badv),
    .keep_badi_o (keep_badi)
  );

  exc_vec_calc #(.AW(XLEN), .IW(VIDX_W), .VSW(VSW)) u_vec (
    .base_i (base_i),
    .idx_i  (vidx),
    .vs_i   (vs_i),
    .tgt_o  (vec_pc)
  );

  always_comb begin
    int_norm = cur_ie_i && !dst_q && live_any;
    int_dbg  = cur_ie_i &&  dst_q && live_any;
    if (exc_valid_i)   kind = is_dbp ? K_DBG_BP : K_EXC;
    else if (int_norm) kind = K_INT;
    else if (int_dbg)  kind = K_DBG_INT;
    else               kind = K_NONE;

    commit     = take_i && (kind != K_NONE);
    enter_norm = commit && ((kind == K_EXC) || (kind == K_INT));
    enter_dbg  = commit && ((kind == K_DBG_BP) || (kind == K_DBG_INT));
    badv_en    = commit && (kind == K_EXC) && set_badv;
    badi_en    = commit && ((kind == K_EXC) || (kind == K_DBG_BP)) && keep_badi;

    vidx   = (kind == K_INT) ? VIDX_W'(EXT_BASE) + VIDX_W'(win_line)
                             : VIDX_W'(exc_code_i);
    code_d = (kind == K_INT) ? '0 : exc_code_i;
    sub_d  = (kind == K_INT) ? '0 : exc_sub_i;
    da_d   = rf_flag_i ? 1'b1 : cur_da_i;
    pg_d   = rf_flag_i ? 1'b0 : cur_pg_i;

    if (enter_dbg)                        tgt_pc = base_i + XLEN'(DBG_OFS);
    else if (kind == K_EXC && rf_flag_i)  tgt_pc = rf_base_i;
    else                                  tgt_pc = vec_pc;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      redir_q <= 1'b0;
      pc_q    <= '0;
    end else begin
      pend_q  <= irq_i;
      redir_q <= commit;
      if (commit) pc_q <= tgt_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plv_q <= '0; ie_q <= 1'b0; da_q <= 1'b1; pg_q <= 1'b0;
      splv_q <= '0; sie_q <= 1'b0; rfplv_q <= '0; rfie_q <= 1'b0;
      code_q <= '0; sub_q <= '0; ret_q <= '0; rfret_q <= '0;
      badv_q <= '0; badi_q <= '0;
    end else begin
      if (enter_norm) begin
        plv_q <= '0;
        ie_q  <= 1'b0;
        da_q  <= da_d;
        pg_q  <= pg_d;
      end
      if (enter_norm && rf_flag_i) begin
        rfplv_q <= cur_plv_i;
        rfie_q  <= cur_ie_i;
        rfret_q <= pc_i[XLEN-1:2];
      end
      if (enter_norm && !rf_flag_i) begin
        splv_q <= cur_plv_i;
        sie_q  <= cur_ie_i;
        ret_q  <= pc_i;
        code_q <= code_d;
        sub_q  <= sub_d;
      end
      if (badv_en) badv_q <= pc_i;
      if (badi_en) badi_q <= insn_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= 1'b0; dbp_q <= 1'b0; dint_q <= 1'b0;
      dcode_q <= '0; dret_q <= '0;
    end else begin
      if (enter_dbg) begin
        dst_q  <= 1'b1;
        dret_q <= pc_i;
      end
      if (enter_dbg && kind == K_DBG_BP) begin
        dbp_q   <= 1'b1;
        dcode_q <= DBG_ECODE;
      end
      if (enter_dbg && kind == K_DBG_INT) dint_q <= 1'b1;
    end
  end

  // ---------------- outputs ----------------
  assign irq_pending_o = |pend_q;
  assign int_avail_o   = int_norm;
  assign redirect_o    = redir_q;
  assign pc_o          = pc_q;
  assign pending_o     = pend_q;
  assign cause_code_o  = code_q;
  assign cause_sub_o   = sub_q;
  assign mode_plv_o    = plv_q;
  assign mode_ie_o     = ie_q;
  assign mode_da_o     = da_q;
  assign mode_pg_o     = pg_q;
  assign sav_plv_o     = splv_q;
  assign sav_ie_o      = sie_q;
  assign rf_sav_plv_o  = rfplv_q;
  assign rf_sav_ie_o   = rfie_q;
  assign ret_pc_o      = ret_q;
  assign rf_ret_o      = rfret_q;
  assign badv_o        = badv_q;
  assign badi_o        = badi_q;
  assign dbg_state_o   = dst_q;
  assign dbg_bp_o      = dbp_q;
  assign dbg_int_o     = dint_q;
  assign dbg_code_o    = dcode_q;
  assign dbg_ret_o     = dret_q;

  // ---------------- assertions ----------------
  // R1
  pend_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pending_o == $past(irq_i));

  // R2
  int_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_avail_o |-> (cur_ie_i && !dbg_state_o && |(pending_o & lie_i)));

  // R6
  idle_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !exc_valid_i && !(cur_ie_i && |(pending_o & lie_i)))
      |=> (!redirect_o && $stable(pc_o) && $stable(ret_pc_o)));

  // R7
  dbg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && exc_valid_i && exc_code_i == C_DBP)
      |=> (dbg_state_o && dbg_bp_o && pc_o == $past(base_i) + XLEN'(DBG_OFS)));

  // R9
  refill_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && exc_valid_i && rf_flag_i && exc_code_i != C_DBP)
      |=> (rf_ret_o == $past(pc_i[XLEN-1:2]) && mode_da_o && !mode_pg_o
           && pc_o == $past(rf_base_i)));

  // R11
  force_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && exc_valid_i && exc_code_i != C_DBP)
      |=> (mode_plv_o == 2'b00 && !mode_ie_o));

  // R14
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> !redirect_o);
endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb_top;
  localparam int XLEN = 64;
  localparam int NIRQ = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NIRQ-1:0] irq_i = '0, lie_i = '0;
  logic [2:0]  vs_i = '0;
  logic [63:0] base_i = '0, rf_base_i = '0, pc_i = '0;
  logic        rf_flag_i = 1'b0, cur_ie_i = 1'b0, cur_da_i = 1'b0, cur_pg_i = 1'b0;
  logic [1:0]  cur_plv_i = '0;
  logic [31:0] insn_i = '0;
  logic        exc_valid_i = 1'b0, take_i = 1'b0;
  logic [5:0]  exc_code_i = '0;
  logic [8:0]  exc_sub_i = '0;

  logic irq_pending_o, int_avail_o, redirect_o;
  logic [63:0] pc_o, ret_pc_o, badv_o, dbg_ret_o;
  logic [61:0] rf_ret_o;
  logic [NIRQ-1:0] pending_o;
  logic [5:0] cause_code_o, dbg_code_o;
  logic [8:0] cause_sub_o;
  logic [1:0] mode_plv_o, sav_plv_o, rf_sav_plv_o;
  logic mode_ie_o, mode_da_o, mode_pg_o, sav_ie_o, rf_sav_ie_o;
  logic [31:0] badi_o;
  logic dbg_state_o, dbg_bp_o, dbg_int_o;

  exc_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .lie_i(lie_i), .vs_i(vs_i),
    .base_i(base_i), .rf_base_i(rf_base_i), .rf_flag_i(rf_flag_i),
    .cur_plv_i(cur_plv_i), .cur_ie_i(cur_ie_i), .cur_da_i(cur_da_i), .cur_pg_i(cur_pg_i),
    .pc_i(pc_i), .insn_i(insn_i), .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
    .exc_sub_i(exc_sub_i), .take_i(take_i),
    .irq_pending_o(irq_pending_o), .int_avail_o(int_avail_o), .redirect_o(redirect_o),
    .pc_o(pc_o), .pending_o(pending_o), .cause_code_o(cause_code_o), .cause_sub_o(cause_sub_o),
    .mode_plv_o(mode_plv_o), .mode_ie_o(mode_ie_o), .mode_da_o(mode_da_o), .mode_pg_o(mode_pg_o),
    .sav_plv_o(sav_plv_o), .sav_ie_o(sav_ie_o), .rf_sav_plv_o(rf_sav_plv_o),
    .rf_sav_ie_o(rf_sav_ie_o), .ret_pc_o(ret_pc_o), .rf_ret_o(rf_ret_o), .badv_o(badv_o),
    .badi_o(badi_o), .dbg_state_o(dbg_state_o), .dbg_bp_o(dbg_bp_o), .dbg_int_o(dbg_int_o),
    .dbg_code_o(dbg_code_o), .dbg_ret_o(dbg_ret_o)
  );

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  // model state
  logic [63:0] m_pc, m_ret, m_rfret, m_badv, m_dret;
  logic [31:0] m_badi;
  logic [5:0]  m_code, m_dcode;
  logic [8:0]  m_sub;
  logic [1:0]  m_plv, m_splv, m_rfplv;
  logic        m_ie, m_da, m_pg, m_sie, m_rfie, m_dbg, m_dbp, m_dint;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL R14 watchdog: actual %0d cycles expected completion", cyc);
        summary();
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] vec_ofs(input int idx, input logic [2:0] vs);
    if (vs == 3'd0) return 64'd0;
    return 64'(idx) * (64'd4 << vs);
  endfunction

  function automatic bit badv_code(input logic [5:0] c);
    return (c >= 6'h0B) && (c <= 6'h12);
  endfunction

  function automatic bit badi_code(input logic [5:0] c, input logic [8:0] s);
    return !((c == 6'h00) || (c == 6'h03) || (c == 6'h08 && s == 9'd0));
  endfunction

  task automatic model_reset();
    m_pc = '0; m_ret = '0; m_rfret = '0; m_badv = '0; m_dret = '0; m_badi = '0;
    m_code = '0; m_dcode = '0; m_sub = '0; m_plv = '0; m_splv = '0; m_rfplv = '0;
    m_ie = 0; m_da = 1; m_pg = 0; m_sie = 0; m_rfie = 0; m_dbg = 0; m_dbp = 0; m_dint = 0;
  endtask

  task automatic check_all(input bit exp_redir);
    check("R14 redirect", redirect_o, exp_redir);
    check("R3 R5 pc", pc_o, m_pc);
    check("R5 cause code", cause_code_o, m_code);
    check("R5 cause sub", cause_sub_o, m_sub);
    check("R11 plv", mode_plv_o, m_plv);
    check("R11 ie", mode_ie_o, m_ie);
    check("R9 R10 da", mode_da_o, m_da);
    check("R9 R10 pg", mode_pg_o, m_pg);
    check("R10 saved plv", sav_plv_o, m_splv);
    check("R10 saved ie", sav_ie_o, m_sie);
    check("R10 return", ret_pc_o, m_ret);
    check("R9 refill plv", rf_sav_plv_o, m_rfplv);
    check("R9 refill ie", rf_sav_ie_o, m_rfie);
    check("R9 refill return", 64'(rf_ret_o), m_rfret);
    check("R12 badv", badv_o, m_badv);
    check("R13 badi", badi_o, m_badi);
    check("R7 R8 dbg state", dbg_state_o, m_dbg);
    check("R7 dbg bp", dbg_bp_o, m_dbp);
    check("R8 dbg int", dbg_int_o, m_dint);
    check("R7 dbg code", dbg_code_o, m_dcode);
    check("R7 R8 dbg return", dbg_ret_o, m_dret);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    take_i = 1'b0; exc_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    check_all(1'b0);
  endtask

  task automatic txn(input logic [NIRQ-1:0] irqv, input logic [NIRQ-1:0] liev,
                     input logic [2:0] vs, input logic ie, input logic [1:0] plv,
                     input logic da, input logic pg, input logic rf,
                     input logic exv, input logic [5:0] code, input logic [8:0] sub,
                     input logic [63:0] pcv, input logic [31:0] insn,
                     input logic [63:0] base, input logic [63:0] rfbase);
    bit any_en, redir;
    int hi;
    @(negedge clk);
    irq_i = irqv; lie_i = liev; vs_i = vs; cur_ie_i = ie; cur_plv_i = plv;
    cur_da_i = da; cur_pg_i = pg; rf_flag_i = rf; base_i = base; rf_base_i = rfbase;
    @(negedge clk);
    check("R1 pending status", 64'(pending_o), 64'(irqv));
    check("R1 pending any", irq_pending_o, |irqv);
    any_en = ie && (|(irqv & liev));
    check("R2 int avail", int_avail_o, any_en && !m_dbg);
    exc_valid_i = exv; exc_code_i = code; exc_sub_i = sub; pc_i = pcv; insn_i = insn;
    take_i = 1'b1;
    hi = 0;
    for (int i = 0; i < NIRQ; i++) if (irqv[i] && liev[i]) hi = i;
    redir = 1'b1;
    if (exv && code == 6'h1A) begin
      m_dbg = 1; m_dbp = 1; m_dcode = 6'h0C; m_dret = pcv; m_badi = insn;
      m_pc = base + 64'h480;
    end else if (exv || (any_en && !m_dbg)) begin
      if (rf) begin
        m_rfplv = plv; m_rfie = ie; m_rfret = pcv >> 2; m_da = 1; m_pg = 0;
      end else begin
        m_splv = plv; m_sie = ie; m_ret = pcv; m_da = da; m_pg = pg;
        m_code = exv ? code : 6'd0; m_sub = exv ? sub : 9'd0;
      end
      m_plv = 0; m_ie = 0;
      if (exv && badv_code(code)) m_badv = pcv;
      if (exv && badi_code(code, sub)) m_badi = insn;
      if (!exv)    m_pc = base + vec_ofs(64 + hi, vs);
      else if (rf) m_pc = rfbase;
      else         m_pc = base + vec_ofs(int'(code), vs);
    end else if (any_en && m_dbg) begin
      m_dint = 1; m_dret = pcv; m_pc = base + 64'h480;
    end else begin
      redir = 1'b0;
    end
    @(negedge clk);
    take_i = 1'b0; exc_valid_i = 1'b0;
    check_all(redir);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  logic [5:0] codes [13] = '{6'h01, 6'h02, 6'h03, 6'h04, 6'h08, 6'h0B, 6'h0C,
                             6'h0D, 6'h0E, 6'h0F, 6'h10, 6'h11, 6'h12};

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R14 reset state
    check_all(1'b0);

    // R3 R4: all lines, spacing 0 collapses onto base
    txn('1, '1, 3'd0, 1, 2'd3, 0, 1, 0, 0, 6'd0, 9'd0, 64'h1000, 32'h0, 64'h8000, 64'h0);
    // R3 R4: lines 2 and 5, spacing 8 -> base + 69*8
    txn(13'h024, 13'h024, 3'd1, 1, 2'd1, 1, 0, 0, 0, 6'd0, 9'd0, 64'h2000, 32'h0, 64'h9000, 64'h0);
    // R1 R6: masked line, take has no effect
    txn(13'h080, 13'h17F, 3'd2, 1, 2'd2, 0, 0, 0, 0, 6'd0, 9'd0, 64'h3000, 32'h0, 64'hA000, 64'h0);
    // R2 R6: global enable off
    txn(13'h001, 13'h001, 3'd2, 0, 2'd2, 0, 0, 0, 0, 6'd0, 9'd0, 64'h3004, 32'h0, 64'hA000, 64'h0);
    // R6 R12: exception beats pending interrupt
    txn(13'h1FFF, 13'h1FFF, 3'd3, 1, 2'd3, 0, 1, 0, 1, 6'h0B, 9'd2, 64'h4000, 32'hDEAD_BEEF, 64'hB000, 64'h0);
    // R9: refill exception
    txn(13'h0, 13'h0, 3'd1, 1, 2'd3, 0, 1, 1, 1, 6'h01, 9'd0, 64'h5008, 32'h1234_5678, 64'hC000, 64'hE000);
    // R13: fetch address error captures nothing, memory one does
    txn(13'h0, 13'h0, 3'd1, 0, 2'd0, 0, 1, 0, 1, 6'h08, 9'd0, 64'h6000, 32'hAAAA_5555, 64'hC000, 64'h0);
    txn(13'h0, 13'h0, 3'd1, 0, 2'd0, 0, 1, 0, 1, 6'h08, 9'd1, 64'h6004, 32'h5555_AAAA, 64'hC000, 64'h0);
    // R7 R8: breakpoint, then interrupt while in debug
    txn(13'h0, 13'h0, 3'd2, 1, 2'd3, 1, 0, 0, 1, 6'h1A, 9'd0, 64'h7000, 32'h0BAD_0001, 64'hD000, 64'h0);
    txn(13'h010, 13'h010, 3'd2, 1, 2'd3, 1, 0, 0, 0, 6'd0, 9'd0, 64'h7010, 32'h0, 64'hD000, 64'h0);
    do_reset();

    for (int n = 0; n < 400; n++) begin
      logic exv;
      logic [5:0] code;
      exv  = ($urandom % 3) == 0;
      code = codes[$urandom % 13];
      if (($urandom % 25) == 0) begin exv = 1; code = 6'h1A; end
      txn(NIRQ'($urandom), NIRQ'($urandom), 3'($urandom), 1'($urandom % 4 != 0),
          2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
          exv, code, 9'($urandom % 3), r64(), $urandom, r64(), r64());
      if (m_dbg && ($urandom % 4) == 0) do_reset();
    end

    summary();
  end
endmodule